// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes one global load request from a whole warp and reduces it to the fewest memory transactions that can serve it. The request carries one byte address per lane and an active mask. Each lane reads one aligned 4-byte word. The block emits one transaction for each distinct 128-byte line that the active lanes touch. A transaction carries the line-aligned address and a 4-bit mask that names the 32-byte sectors to fetch.

The request input and the transaction output both use valid/ready handshakes. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle. A transaction moves on a cycle where `txn_valid` and `txn_ready` are both high. While `txn_ready` is held low, the offered transaction stays where it is and does not change. The downstream side may stall for any number of cycles.

For each lane, the block also records which transaction holds that lane's word and at which byte offset within the line. The data-return path uses this map. `done` pulses for one cycle when the request is fully issued.

Top module: `warp_coalescer`

## Requirements
- R1: Every transaction address equals the byte address of an active lane with bits [6:0] cleared. Transaction addresses are therefore 128-byte aligned.
- R2: Bit s of a transaction's sector mask is set if and only if some active lane in that line has address bits [6:5] equal to s.
- R3: The number of transactions issued for a request equals the number of distinct 128-byte lines touched by active lanes.
- R4: Transactions leave in ascending order of the lowest-numbered active lane that touches each line.
- R5: An inactive lane adds no transaction and no sector bit. A request with an all-zero mask issues no transaction and raises `done` in the cycle after it is accepted.
- R6: While `txn_valid` is high and `txn_ready` is low, `txn_valid`, `txn_addr` and `txn_sectors` stay unchanged on the next cycle.
- R7: `req_ready` is high only when no transaction is pending. It returns high in the cycle after the last transaction is taken, and never while `txn_valid` is high.
- R8: From `done` until the next acceptance, the following holds. For each active lane, `lane_txn` gives the 0-based issue number of the transaction that carries its line. For each active lane, `lane_off` gives its address bits [6:0]. Inactive lanes report transaction number 0.
- R9: `done` is high for exactly the cycle after the last transaction handshake, or after acceptance of an empty request. It is never high at any other time.
- R10: A full warp reading 32 consecutive words that start on a line boundary yields exactly one transaction with sector mask 4'b1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Warp request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | LANES*ADDR_W | Byte address per lane; lane i in bits [i*ADDR_W +: ADDR_W] |
| req_mask | input | LANES | Active lanes |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Downstream takes the transaction |
| txn_addr | output | ADDR_W | Line-aligned transaction address |
| txn_sectors | output | 4 | Sectors to fetch; bit s means bytes [32s, 32s+31] of the line |
| lane_txn | output | LANES*IDX_W | Per-lane transaction number; lane i in bits [i*IDX_W +: IDX_W] |
| lane_off | output | LANES*7 | Per-lane byte offset in the line; lane i in bits [i*7 +: 7] |
| done | output | 1 | One-cycle pulse when a request is fully issued |

## Verification
The bound checker watches the properties that hold on every cycle. Offered addresses must be line aligned, and offered sector masks must never be empty. A stalled transaction must stay unchanged. The request side must be closed while a transaction is pending. `done` may only appear while the block is idle. The per-request transaction count is also kept within the lane count. Other behaviours need a reference model, so only the bench scenarios can show them. These are the exact transaction count, the exact sector masks, the first-touch ordering, the per-lane map and the timing of `done`. A scoreboard computes all of these independently, under both a steady `txn_ready` and a randomly stalling one.

// File: rtl/wc_pkg.sv
package wc_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} wc_state_t;
endpackage

// File: rtl/wc_lane_split.sv
module wc_lane_split #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 7,
  parameter int SEC_W  = 2,
  localparam int TAG_W = ADDR_W - OFF_W,
  localparam int NSEC  = 1 << SEC_W
) (
  input  logic [LANES*ADDR_W-1:0] addr_flat,
  output logic [LANES*TAG_W-1:0]  tag_flat,
  output logic [LANES*NSEC-1:0]   sec_flat,
  output logic [LANES*OFF_W-1:0]  off_flat
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [ADDR_W-1:0] a;
    assign a = addr_flat[g*ADDR_W +: ADDR_W];
    assign tag_flat[g*TAG_W +: TAG_W] = a[ADDR_W-1:OFF_W];
    assign off_flat[g*OFF_W +: OFF_W] = a[OFF_W-1:0];
    assign sec_flat[g*NSEC +: NSEC]   = NSEC'(1) << a[OFF_W-1 -: SEC_W];
  end
endmodule

// File: rtl/wc_pick.sv
module wc_pick #(
  parameter int LANES = 32,
  parameter int TAG_W = 25,
  parameter int NSEC  = 4,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0]       pending,
  input  logic [LANES*TAG_W-1:0] tag_flat,
  input  logic [LANES*NSEC-1:0]  sec_flat,
  output logic [LANES-1:0]       match,
  output logic [TAG_W-1:0]       tag_sel,
  output logic [NSEC-1:0]        sectors
);
  logic [IDX_W-1:0] sel;
  logic             found;

  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (!found && pending[i]) begin
        sel   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  assign tag_sel = tag_flat[sel*TAG_W +: TAG_W];

  for (genvar g = 0; g < LANES; g++) begin : g_cmp
    assign match[g] = pending[g] && (tag_flat[g*TAG_W +: TAG_W] == tag_sel);
  end

  always_comb begin
    sectors = '0;
    for (int i = 0; i < LANES; i++)
      if (match[i]) sectors = sectors | sec_flat[i*NSEC +: NSEC];
  end
endmodule

// File: rtl/wc_lane_map.sv
module wc_lane_map #(
  parameter int LANES = 32,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   update,
  input  logic [LANES-1:0]       match,
  input  logic [IDX_W-1:0]       idx,
  output logic [LANES*IDX_W-1:0] map_flat
);
  for (genvar g = 0; g < LANES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n || clear)
        map_flat[g*IDX_W +: IDX_W] <= '0;
      else if (update && match[g])
        map_flat[g*IDX_W +: IDX_W] <= idx;
    end
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 32,
  localparam int OFF_W = 7,
  localparam int SEC_W = 2,
  localparam int NSEC  = 1 << SEC_W,
  localparam int TAG_W = ADDR_W - OFF_W,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]        req_mask,
  output logic                    txn_valid,
  input  logic                    txn_ready,
  output logic [ADDR_W-1:0]       txn_addr,
  output logic [NSEC-1:0]         txn_sectors,
  output logic [LANES*IDX_W-1:0]  lane_txn,
  output logic [LANES*OFF_W-1:0]  lane_off,
  output logic                    done
);
  import wc_pkg::*;

  wc_state_t               state_q;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [LANES-1:0]        pending_q;
  logic [IDX_W-1:0]        cnt_q;
  logic                    done_q;

  logic [LANES*TAG_W-1:0]  tag_flat;
  logic [LANES*NSEC-1:0]   sec_flat;
  logic [LANES-1:0]        match;
  logic [TAG_W-1:0]        tag_sel;
  logic [LANES-1:0]        remain;
  logic                    accept, fire;

  assign req_ready = (state_q == ST_IDLE);
  assign txn_valid = (state_q == ST_BUSY);
  assign accept    = req_valid && req_ready;
  assign fire      = txn_valid && txn_ready;
  assign remain    = pending_q & ~match;
  assign txn_addr  = {tag_sel, {OFF_W{1'b0}}};
  assign done      = done_q;

  wc_lane_split #(.LANES(LANES), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SEC_W(SEC_W)) u_split (
    .addr_flat(addr_q), .tag_flat(tag_flat), .sec_flat(sec_flat), .off_flat(lane_off)
  );

  wc_pick #(.LANES(LANES), .TAG_W(TAG_W), .NSEC(NSEC)) u_pick (
    .pending(pending_q), .tag_flat(tag_flat), .sec_flat(sec_flat),
    .match(match), .tag_sel(tag_sel), .sectors(txn_sectors)
  );

  wc_lane_map #(.LANES(LANES)) u_map (
    .clk(clk), .rst_n(rst_n), .clear(accept), .update(fire),
    .match(match), .idx(cnt_q), .map_flat(lane_txn)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      pending_q <= '0;
      cnt_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        addr_q    <= req_addr;
        pending_q <= req_mask;
        cnt_q     <= '0;
        if (req_mask == '0) begin
          done_q <= 1'b1;
        end else begin
          state_q <= ST_BUSY;
        end
      end else if (fire) begin
        pending_q <= remain;
        cnt_q     <= cnt_q + 1'b1;
        if (remain == '0) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wc_checker.sv
module wc_checker #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 32,
  localparam int OFF_W = 7,
  localparam int NSEC  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              txn_valid,
  input logic              txn_ready,
  input logic [ADDR_W-1:0] txn_addr,
  input logic [NSEC-1:0]   txn_sectors,
  input logic              done
);
  logic [$clog2(LANES+1):0] seen;

  always_ff @(posedge clk) begin
    if (!rst_n || (req_valid && req_ready)) seen <= '0;
    else if (txn_valid && txn_ready) seen <= seen + 1'b1;
  end

  // R1
  line_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> txn_addr[OFF_W-1:0] == '0);

  // R2
  sectors_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> txn_sectors != '0);

  // R3
  txn_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen <= LANES);

  // R6
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_addr) && $stable(txn_sectors)));

  // R7
  closed_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> !req_ready);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && !txn_valid));
endmodule

bind warp_coalescer wc_checker #(.LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_addr(txn_addr),
  .txn_sectors(txn_sectors), .done(done)
);

// File: tb/warp_coalescer_bench.sv
module warp_coalescer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 32;
  localparam int AW = 32;
  localparam int IW = 5;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, txn_ready = 0;
  logic [LANES*AW-1:0] req_addr = '0;
  logic [LANES-1:0] req_mask = '0;
  logic req_ready, txn_valid, done;
  logic [AW-1:0] txn_addr;
  logic [3:0] txn_sectors;
  logic [LANES*IW-1:0] lane_txn;
  logic [LANES*7-1:0] lane_off;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_coalescer u_warp_coalescer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mask(req_mask), .txn_valid(txn_valid),
    .txn_ready(txn_ready), .txn_addr(txn_addr), .txn_sectors(txn_sectors),
    .lane_txn(lane_txn), .lane_off(lane_off), .done(done)
  );

  int tests = 0, fails = 0;
  logic [35:0] exp_q[$];
  logic [AW-1:0] stim[LANES];
  int  exp_idx[LANES];
  bit  done_due = 0;
  bit  rand_ready = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // ready driver
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    txn_ready = rand_ready ? lfsr[0] : 1'b1;
  end

  // monitor
  bit stall_prev = 0;
  logic [AW-1:0] a_prev;
  logic [3:0] s_prev;
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (done_due) begin
        chk(done === 1'b1, "R9 done after last txn", done, 1);
        chk(req_ready === 1'b1, "R7 ready after last txn", req_ready, 1);
        done_due = 0;
      end else if (done === 1'b1) begin
        chk(0, "R9 unexpected done", 1, 0);
      end
      if (stall_prev)
        chk(txn_valid && txn_addr == a_prev && txn_sectors == s_prev,
            "R6 hold under stall", {txn_addr, txn_sectors}, {a_prev, s_prev});
      stall_prev = txn_valid && !txn_ready;
      a_prev = txn_addr; s_prev = txn_sectors;
      if (txn_valid && txn_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R3 extra transaction", txn_addr, 0);
        end else begin
          logic [35:0] e;
          e = exp_q.pop_front();
          chk({txn_addr, txn_sectors} == e, "R1 R2 R4 transaction",
              {txn_addr, txn_sectors}, e);
          if (exp_q.size() == 0) done_due = 1;
        end
      end
    end
  end

  task automatic run_warp(input logic [LANES-1:0] m, input string tag);
    logic [AW-1:0] lines[LANES];
    logic [3:0] secs[LANES];
    int n = 0;
    for (int l = 0; l < LANES; l++) begin
      exp_idx[l] = 0;
      if (m[l]) begin
        int j;
        logic [AW-1:0] ln;
        ln = stim[l] & ~32'h7F;
        j = n;
        for (int k = 0; k < n; k++) if (lines[k] == ln && j == n) j = k;
        if (j == n) begin lines[n] = ln; secs[n] = 4'b0; n++; end
        secs[j] = secs[j] | (4'b1 << stim[l][6:5]);
        exp_idx[l] = j;
      end
    end
    for (int k = 0; k < n; k++) exp_q.push_back({lines[k], secs[k]});
    @(posedge clk); #1;
    while (!req_ready) begin @(posedge clk); #1; end
    for (int l = 0; l < LANES; l++) req_addr[l*AW +: AW] = stim[l];
    req_mask = m;
    req_valid = 1;
    @(posedge clk); #1;
    req_valid = 0;
    if (n == 0) done_due = 1;
    @(negedge clk);
    while (done !== 1'b1) @(negedge clk);
    chk(exp_q.size() == 0, {"R3 count ", tag}, exp_q.size(), 0);
    for (int l = 0; l < LANES; l++) begin
      chk(lane_txn[l*IW +: IW] == IW'(exp_idx[l]), {"R8 lane_txn ", tag},
          lane_txn[l*IW +: IW], exp_idx[l]);
      if (m[l])
        chk(lane_off[l*7 +: 7] == stim[l][6:0], {"R8 lane_off ", tag},
            lane_off[l*7 +: 7], stim[l][6:0]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(req_ready === 1'b1, "R7 reset ready", req_ready, 1);
    chk(txn_valid === 1'b0, "R7 reset no txn", txn_valid, 0);
    chk(done === 1'b0, "R9 reset no done", done, 0);
    rst_n = 1;

    // R10 coalesced warp
    for (int l = 0; l < LANES; l++) stim[l] = 32'h1000 + 4*l;
    run_warp('1, "R10 coalesced");
    // R3 stride 8: two lines
    for (int l = 0; l < LANES; l++) stim[l] = 32'h2000 + 8*l;
    run_warp('1, "stride8");
    // R4 descending addresses with duplicates
    for (int l = 0; l < LANES; l++) stim[l] = 32'h8000 - 32'((l % 11) * 36) & ~32'h3;
    run_warp('1, "R4 descending");
    // broadcast
    for (int l = 0; l < LANES; l++) stim[l] = 32'h3044;
    run_warp('1, "broadcast");
    // R5 odd lanes, one line each; even lanes would touch other sectors
    for (int l = 0; l < LANES; l++) stim[l] = (l % 2) ? 32'h10000 + 128*l : 32'h3060;
    run_warp(32'hAAAA_AAAA, "R5 odd lanes");
    // R5 masked lanes drop sectors
    for (int l = 0; l < LANES; l++) stim[l] = 32'h5000 + 4*l;
    run_warp(32'h0000_00FF, "R5 partial");
    // R5 empty request
    run_warp('0, "R5 empty");
    // stalling downstream
    rand_ready = 1;
    for (int l = 0; l < LANES; l++) stim[l] = 32'h40000 + 32'(((l * 7) % 32) * 160);
    run_warp('1, "R6 scattered stall");
    for (int l = 0; l < LANES; l++) stim[l] = 32'h7000 + 32'(((l * 13) % 64) * 4);
    run_warp(32'hF0F0_0F0F, "R6 two lines stall");
    run_warp('0, "R5 empty stall");
    rand_ready = 0;
    repeat (4) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule